// File: doc/BRIEF.md
# Status Register and Write-Protection Gate

This block sits beside the command decoder of a serial non-volatile memory. It keeps the write-enable latch and a small status register. The status register holds a two-bit block-protect code and a protect-enable flag. It merges these with an active-low hardware protect pin and decides, for every request, whether a status-register write or an array write may go ahead. It also produces the byte returned by a read-status command.

The decoder sends it single-cycle pulses. One pulse sets the enable latch and another clears it. The decoder also sends a status-write request together with its data byte, and an array-write request together with the starting address it latched. A level input reports that an internal write cycle is running. When that level falls, the cycle has finished: a status write accepted earlier takes effect at that point, and the enable latch drops. The non-volatile cells are modelled as resettable flops.

Top module: `wp_guard`

## Requirements
- R1: While idle, `statusByte` is {protect-enable, 3'b000, BP[1], BP[0], WEN, 1'b0}, with bit 0 the active-low ready flag.
- R2: While `busy` is high, `statusByte` reads 8'hFF.
- R3: Block-protect code 00 locks no address. Code 01 locks the addresses whose two top bits are 11. Code 10 locks those whose top bit is 1. Code 11 locks every address. An array write to a locked address is never permitted.
- R4: When `wpN` is low and protect-enable is 1, every status write is refused, so protect-enable cannot be cleared while the pin stays low.
- R5: With WEN at 0, both `statusWrOk` and `arrayWrOk` stay 0 whatever the other inputs are.
- R6: While `busy` is high, both permits are 0 and the `wenSet` and `wenClr` pulses have no effect on WEN.
- R7: WEN is 0 after reset. `wenClr` clears it whatever the state of `wpN`, and it clears in the cycle `busy` falls. A clear wins over a `wenSet` in the same cycle.
- R8: An accepted status write stores data bits 7, 3 and 2 as protect-enable, BP[1] and BP[0] in the cycle `busy` falls. A fall of `wpN` after acceptance does not cancel it.
- R9: Protect-enable and both block-protect bits are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wenSet | input | 1 | Pulse: set the write-enable latch |
| wenClr | input | 1 | Pulse: clear the write-enable latch |
| statusWrReq | input | 1 | Pulse: status-register write requested |
| statusWrData | input | 8 | Data byte of the status write |
| arrayWrReq | input | 1 | Pulse: array write requested |
| arrayWrAddr | input | ADDR_W | Latched start address of the array write |
| busy | input | 1 | Internal write cycle running |
| wpN | input | 1 | Hardware write-protect pin, active low |
| statusWrOk | output | 1 | Status write permitted this cycle |
| arrayWrOk | output | 1 | Array write permitted this cycle |
| statusByte | output | 8 | Byte for a read-status command |

## Verification
Completion of a write cycle (`busy` falling) can arrive in the same cycle as a `wenSet` pulse or a fresh status-write request. In that cycle the latch clear, the set and the commit of the pending status data all compete for the same flops. The bench drops `busy` in the very cycle it pulses `wenSet`, and separately in the cycle it raises a new status write. A behavioural model of the register states, stepped every clock, then judges the following cycle's status byte and permits.

// File: rtl/wpctl_pkg.sv
package wpctl_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch an accepted status write
    logic commit;    // apply the latched status write
  } dpStrobe_t;

  localparam logic [1:0] BP_NONE    = 2'b00;
  localparam logic [1:0] BP_QUARTER = 2'b01;
  localparam logic [1:0] BP_HALF    = 2'b10;
  localparam logic [1:0] BP_ALL     = 2'b11;
endpackage

// File: rtl/wpctl_ctrl.sv
module wpctl_ctrl
  import wpctl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wenSet,
  input  logic      wenClr,
  input  logic      statusWrReq,
  input  logic      arrayWrReq,
  input  logic      busy,
  input  logic      wpN,
  input  logic      wpEn,
  input  logic      addrLocked,
  output logic      wen,
  output logic      statusWrOk,
  output logic      arrayWrOk,
  output dpStrobe_t strobe
);
  logic busyQ;
  logic busyFall;
  logic hwLock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyQ <= 1'b0;
    else       busyQ <= busy;
  end

  assign busyFall = busyQ & ~busy;
  assign hwLock   = ~wpN & wpEn;

  assign statusWrOk = statusWrReq & wen & ~busy & ~hwLock;
  assign arrayWrOk  = arrayWrReq & wen & ~busy & ~addrLocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         wen <= 1'b0;
    else if (busyFall) wen <= 1'b0;
    else if (!busy) begin
      if (wenClr)      wen <= 1'b0;
      else if (wenSet) wen <= 1'b1;
    end
  end

  always_comb begin
    strobe.capture = statusWrOk;
    strobe.commit  = busyFall;
  end
endmodule

// File: rtl/wpctl_dp.sv
module wpctl_dp
  import wpctl_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [7:0]        statusWrData,
  input  logic [ADDR_W-1:0] arrayWrAddr,
  input  logic              busy,
  input  logic              wen,
  output logic              wpEn,
  output logic              addrLocked,
  output logic [7:0]        statusByte
);
  localparam int TOP = ADDR_W - 1;

  logic [1:0] bp;
  logic       pendValid;
  logic [2:0] pendBits;   // {protect-enable, bp1, bp0}
  logic [1:0] topBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wpEn      <= 1'b0;
      bp        <= BP_NONE;
      pendValid <= 1'b0;
      pendBits  <= 3'b000;
    end else begin
      if (strobe.commit && pendValid) begin
        wpEn      <= pendBits[2];
        bp        <= pendBits[1:0];
        pendValid <= 1'b0;
      end
      if (strobe.capture) begin
        pendBits  <= {statusWrData[7], statusWrData[3:2]};
        pendValid <= 1'b1;
      end
    end
  end

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign topBits = arrayWrAddr[TOP -: 2];
    end else begin : g_narrow
      assign topBits = {arrayWrAddr[0], 1'b0};
    end
  endgenerate

  always_comb begin
    unique case (bp)
      BP_NONE:    addrLocked = 1'b0;
      BP_QUARTER: addrLocked = (topBits == 2'b11);
      BP_HALF:    addrLocked = topBits[1];
      default:    addrLocked = 1'b1;
    endcase
  end

  assign statusByte = busy ? 8'hFF : {wpEn, 3'b000, bp, wen, 1'b0};
endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wpctl_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wenSet,
  input  logic              wenClr,
  input  logic              statusWrReq,
  input  logic [7:0]        statusWrData,
  input  logic              arrayWrReq,
  input  logic [ADDR_W-1:0] arrayWrAddr,
  input  logic              busy,
  input  logic              wpN,
  output logic              statusWrOk,
  output logic              arrayWrOk,
  output logic [7:0]        statusByte
);
  dpStrobe_t strobe;
  logic      wen;
  logic      wpEn;
  logic      addrLocked;

  wpctl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wenSet(wenSet), .wenClr(wenClr),
    .statusWrReq(statusWrReq), .arrayWrReq(arrayWrReq), .busy(busy),
    .wpN(wpN), .wpEn(wpEn), .addrLocked(addrLocked), .wen(wen),
    .statusWrOk(statusWrOk), .arrayWrOk(arrayWrOk), .strobe(strobe)
  );

  wpctl_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statusWrData(statusWrData),
    .arrayWrAddr(arrayWrAddr), .busy(busy), .wen(wen), .wpEn(wpEn),
    .addrLocked(addrLocked), .statusByte(statusByte)
  );
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wenClr,
  input logic       busy,
  input logic       wpN,
  input logic       statusWrOk,
  input logic       arrayWrOk,
  input logic [7:0] statusByte
);
  AST_IDLE_LAYOUT: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (statusByte[6:4] == 3'b000 && !statusByte[0])) else $error("idle layout"); // R1
  AST_BUSY_ONES: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> statusByte == 8'hFF) else $error("busy byte"); // R2
  AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && statusByte[3:2] == 2'b11) |-> !arrayWrOk) else $error("full lock"); // R3
  AST_HW_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !wpN && statusByte[7]) |-> !statusWrOk) else $error("hw lock"); // R4
  AST_NEED_WEN: assert property (@(posedge clk) disable iff (!rstN)
    (statusWrOk || arrayWrOk) |-> (!busy && statusByte[1])) else $error("wen gate"); // R5
  AST_BUSY_NO_PERMIT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!statusWrOk && !arrayWrOk)) else $error("busy permit"); // R6
  AST_WEN_DROP_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |=> (busy || !statusByte[1])) else $error("wen end"); // R7
  AST_WEN_DROP_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (wenClr && !busy) |=> (busy || !statusByte[1])) else $error("wen clr"); // R7
endmodule

bind wp_guard wp_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .wenClr(wenClr), .busy(busy), .wpN(wpN),
  .statusWrOk(statusWrOk), .arrayWrOk(arrayWrOk), .statusByte(statusByte)
);

// File: tb/wp_guard_test.sv
module wp_guard_test;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wenSet = 0, wenClr = 0, statusWrReq = 0, arrayWrReq = 0, busy = 0, wpN = 1;
  logic [7:0] statusWrData = 0;
  logic [AW-1:0] arrayWrAddr = 0;
  logic statusWrOk, arrayWrOk;
  logic [7:0] statusByte;

  // staged stimulus
  bit sSet, sClr, sSreq, sAreq, sBusy, sWpN = 1;
  bit [7:0] sData;
  bit [AW-1:0] sAddr;

  // behavioural reference state
  bit mWen, mWpEn, mPend, mPrevBusy;
  bit [1:0] mBp;
  bit [7:0] mPendData;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  wp_guard #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .wenSet(wenSet), .wenClr(wenClr),
    .statusWrReq(statusWrReq), .statusWrData(statusWrData),
    .arrayWrReq(arrayWrReq), .arrayWrAddr(arrayWrAddr), .busy(busy),
    .wpN(wpN), .statusWrOk(statusWrOk), .arrayWrOk(arrayWrOk),
    .statusByte(statusByte)
  );

  function automatic bit locked(bit [1:0] bp, bit [AW-1:0] a);
    int q = a / (1 << (AW - 2));   // quarter index 0..3
    if (bp == 2'b00) return 0;
    if (bp == 2'b01) return q == 3;
    if (bp == 2'b10) return q >= 2;
    return 1;
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit fall, expS, expA;
    bit [7:0] expByte;
    @(negedge clk);
    wenSet = sSet; wenClr = sClr; statusWrReq = sSreq; arrayWrReq = sAreq;
    statusWrData = sData; arrayWrAddr = sAddr; busy = sBusy; wpN = sWpN;
    sSet = 0; sClr = 0; sSreq = 0; sAreq = 0;
    #1;
    fall    = mPrevBusy && !busy;
    expByte = busy ? 8'hFF : {mWpEn, 3'b000, mBp, mWen, 1'b0};
    expS    = statusWrReq && mWen && !busy && !(!wpN && mWpEn);
    expA    = arrayWrReq && mWen && !busy && !locked(mBp, arrayWrAddr);
    check("R1 R2 R7 R8 R9 statusByte", statusByte, expByte);
    check("R4 R5 R6 statusWrOk", statusWrOk, expS);
    check("R3 R5 R6 arrayWrOk", arrayWrOk, expA);
    @(posedge clk);
    if (fall && mPend) begin
      mWpEn = mPendData[7]; mBp = mPendData[3:2]; mPend = 0;
    end
    if (expS) begin mPendData = statusWrData; mPend = 1; end
    if (fall) mWen = 0;
    else if (!busy) begin
      if (wenClr) mWen = 0;
      else if (wenSet) mWen = 1;
    end
    mPrevBusy = busy;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // status write followed by a write cycle of n busy clocks
  task automatic wrStatus(bit [7:0] d, int n);
    sSet = 1; tick();
    sSreq = 1; sData = d; tick();
    sBusy = 1; idle(n);
    sBusy = 0; tick();
  endtask

  task automatic tryArray(bit [AW-1:0] a);
    sSet = 1; tick();
    sAreq = 1; sAddr = a; tick();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    check("R9 R7 reset statusByte", statusByte, 8'h00);
    idle(2);

    // R5: no WEN, both writes refused
    sSreq = 1; sData = 8'h8C; sAreq = 1; sAddr = 0; tick();
    // R1/R8: set protect-enable and full lock
    wrStatus(8'h8C, 4);
    idle(1);
    // R3: full lock blocks array write anywhere
    tryArray(13'h0000);
    tryArray(13'h0ABC);
    // R4: pin low + protect-enable blocks status write, cannot clear
    sWpN = 0; wrStatus(8'h00, 2);
    idle(1);
    // R7: clear works with pin low; clear beats set
    sSet = 1; tick();
    sClr = 1; tick();
    sSet = 1; sClr = 1; tick();
    // release pin, choose quarter lock; drop pin during cycle (R8)
    sWpN = 1;
    sSet = 1; tick();
    sSreq = 1; sData = 8'h04; tick();
    sBusy = 1; tick(); sWpN = 0; idle(3);
    sBusy = 0; tick();
    sWpN = 1;
    // R3 quarter boundaries
    tryArray(13'h17FF);
    tryArray(13'h1800);
    tryArray(13'h1FFF);
    // half lock
    wrStatus(8'h08, 2);
    tryArray(13'h0FFF);
    tryArray(13'h1000);
    // no lock
    wrStatus(8'h00, 2);
    tryArray(13'h1FFF);
    // R6: pulses ignored during busy
    sBusy = 1; tick();
    sSet = 1; tick();
    sSreq = 1; sAreq = 1; tick();
    // busy falls together with wenSet: WEN must stay cleared (R7)
    sBusy = 0; sSet = 1; tick();
    idle(1);
    // busy falls together with new status write (R8)
    sSet = 1; tick();
    sSreq = 1; sData = 8'h04; tick();
    sBusy = 1; idle(2);
    sBusy = 0; sSreq = 1; sData = 8'h08; tick();
    idle(2);
    // WRDI with pin low while unlocked
    sWpN = 0; sSet = 1; tick();
    sClr = 1; tick();
    sAreq = 1; sAddr = 0; tick();
    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule